// File: doc/BRIEF.md
# External Interrupt Controller

This block gathers a set of external interrupt inputs and hands them out to a small number of processor contexts. Each source has a 3-bit priority. Each context has its own per-source enable bits and a 3-bit threshold. Each context has one interrupt output. That output is high while at least one source is eligible for the context: the source is pending, enabled, not already claimed, and its priority is strictly above the context's threshold.

Software in a context reads its claim register and gets the ID of the best eligible source. The best source has the highest priority, and the lowest ID breaks a tie. The read returns 0 when nothing is eligible. The read itself consumes the pending request and locks the source. The locked source is offered to no context until the context that claimed it writes the same ID back to its own claim register. Each source is set up at build time as level-high or rising-edge triggered.

Register access uses a 32-bit single-beat port that is always ready. Read data comes back in the cycle after the request. The byte offsets are:

- Priority of source id: 4·id.
- Enable word w of context c: 0x2000 + 0x80·c + 4·w.
- Threshold of context c: 0x200000 + 0x1000·c.
- Claim/complete register of context c: 0x200000 + 0x1000·c + 4.

The two lowest address bits are ignored.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every context output is 0, all priorities, enables and thresholds read 0, and every claim read returns 0.
- R2: The priority of source id (1 ≤ id < N_SRC) is written and read at byte offset 4·id. Only bits [2:0] are stored, and they read back zero-extended. Source 0 and unmapped offsets ignore writes and read 0. A context's threshold at its page offset 0 behaves the same way.
- R3: Enable word w of context c sits at 0x2000 + 0x80·c + 4·w. Bit (id mod 32) of word (id / 32) enables source id. Bit 0 of word 0 reads 0 always, and words beyond the source count read 0.
- R4: A source is eligible for a context only when its priority is strictly greater than that context's threshold. Priority 0 never interrupts, and threshold 7 blocks everything.
- R5: A claim read returns the eligible source with the highest priority. Among equal priorities it returns the lowest ID. It returns 0 when none is eligible.
- R6: A claim read that returns a non-zero ID clears that source's pending request. It also locks the source against every context. Only a write of the same ID to the claiming context's claim register releases the lock. Writes of 0, of out-of-range IDs, or from another context have no effect.
- R7: A level source is pending exactly while its input is high and it is not locked. Dropping the input before a claim withdraws the request. Holding it high through completion makes the source pending again.
- R8: An edge source (default: IDs N_SRC/2 and up) latches one request per 0-to-1 input transition. The request stays pending after the input falls. An edge that arrives while the source is locked is kept and is forwarded after completion.
- R9: A context output is registered. An input change before clock edge k shows up at the output after edge k+1, and a claim at edge k clears the output after edge k+1.
- R10: bus_ready is always 1. A read request at edge k gives bus_rvalid = 1 with its data after edge k, and a write gives bus_rvalid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | N_SRC | Interrupt inputs indexed by source ID (bit 0 unused) |
| bus_valid | input | 1 | Register request valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Request accepted (always 1) |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | 32 | Read data |
| ctx_irq | output | N_CTX | Registered interrupt line per context |

## Verification
The hardest states to reach are those where a source is locked by one context while its input keeps changing. Examples are an edge that arrives during the lock, a completion written from the wrong context, and a level input that is still high at completion. The bench reaches them in order from the ports. It claims from one context and then probes the second context's claim register. It pulses the input while the lock is held. It writes completions from both contexts, and only then expects the source again. Arbitration is swept over every threshold and several priority patterns, including ties. Each sweep is drained through repeated claim reads that are checked against an order the bench computes.

// File: rtl/eic_pkg.sv
package eic_pkg;

  localparam logic [31:0] PRIO_LIMIT = 32'h0000_1000;
  localparam logic [31:0] EN_BASE    = 32'h0000_2000;
  localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
  localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
  localparam logic [31:0] CTX_STRIDE = 32'h0000_1000;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_PRIO,
    ACC_EN,
    ACC_THR,
    ACC_CLAIM
  } acc_e;

endpackage

// File: rtl/eic_gateway.sv
module eic_gateway #(
  parameter int N_SRC = 16,
  parameter int N_CTX = 2,
  parameter logic [N_SRC-1:0] EDGE_MASK = '0,
  localparam int ID_W  = $clog2(N_SRC),
  localparam int CTX_W = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] irq_src,
  input  logic             claim_fire,
  input  logic [ID_W-1:0]  claim_id,
  input  logic [CTX_W-1:0] claim_ctx,
  input  logic             done_fire,
  input  logic [ID_W-1:0]  done_id,
  input  logic [CTX_W-1:0] done_ctx,
  output logic [N_SRC-1:0] pend,
  output logic [N_SRC-1:0] locked
);

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic             pend_q;
    logic             lock_q;
    logic             lock_n;
    logic             hit_claim;
    logic             hit_done;
    logic [CTX_W-1:0] own_q;

    always_comb begin
      hit_claim = claim_fire && (claim_id == ID_W'(i));
      hit_done  = done_fire && (done_id == ID_W'(i)) && lock_q && (own_q == done_ctx);
      lock_n    = lock_q;
      if (hit_claim) begin
        lock_n = 1'b1;
      end else if (hit_done) begin
        lock_n = 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        lock_q <= 1'b0;
        own_q  <= '0;
      end else begin
        lock_q <= lock_n;
        if (hit_claim) begin
          own_q <= claim_ctx;
        end
      end
    end

    if (EDGE_MASK[i]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          prev_q <= 1'b0;
          pend_q <= 1'b0;
        end else begin
          prev_q <= irq_src[i];
          pend_q <= (pend_q & ~hit_claim) | (irq_src[i] & ~prev_q);
        end
      end
    end else begin : g_level
      always_ff @(posedge clk) begin
        if (rst) begin
          pend_q <= 1'b0;
        end else begin
          pend_q <= irq_src[i] & ~lock_n;
        end
      end
    end

    assign pend[i]   = pend_q;
    assign locked[i] = lock_q;
  end

endmodule

// File: rtl/eic_arbiter.sv
module eic_arbiter #(
  parameter int N_SRC  = 16,
  parameter int PRIO_W = 3,
  localparam int ID_W  = $clog2(N_SRC)
) (
  input  logic [N_SRC*PRIO_W-1:0] prio_flat,
  input  logic [N_SRC-1:0]        en,
  input  logic [N_SRC-1:0]        pend,
  input  logic [N_SRC-1:0]        locked,
  input  logic [PRIO_W-1:0]       thr,
  output logic [ID_W-1:0]         best_id,
  output logic                    any
);

  logic [PRIO_W-1:0] best_p;
  logic [PRIO_W-1:0] cur_p;

  // Ascending scan with a strict compare: the threshold is the starting bar
  // and the earliest ID keeps a tie.
  always_comb begin
    best_p  = thr;
    best_id = '0;
    any     = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      cur_p = prio_flat[i*PRIO_W +: PRIO_W];
      if (pend[i] && !locked[i] && en[i] && (cur_p > best_p)) begin
        best_p  = cur_p;
        best_id = ID_W'(i);
        any     = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eic_pkg::*;
#(
  parameter int N_SRC  = 16,
  parameter int N_CTX  = 2,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 26,
  parameter logic [N_SRC-1:0] EDGE_MASK =
    {{(N_SRC - N_SRC/2){1'b1}}, {(N_SRC/2){1'b0}}}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  irq_src,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_ready,
  output logic              bus_rvalid,
  output logic [31:0]       bus_rdata,
  output logic [N_CTX-1:0]  ctx_irq
);

  localparam int ID_W    = $clog2(N_SRC);
  localparam int CTX_W   = (N_CTX > 1) ? $clog2(N_CTX) : 1;
  localparam int N_WORDS = (N_SRC + 31) / 32;
  localparam int WORD_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

  logic [PRIO_W-1:0] prio_q [N_SRC];
  logic [N_SRC-1:0]  en_q   [N_CTX];
  logic [PRIO_W-1:0] thr_q  [N_CTX];
  logic [ID_W-1:0]   best_id [N_CTX];
  logic [N_CTX-1:0]  ctx_any;

  logic [N_SRC*PRIO_W-1:0] prio_flat;
  logic [N_CTX*PRIO_W-1:0] thr_flat;
  logic [N_CTX*ID_W-1:0]   best_flat;
  logic [N_SRC-1:0]        pend;
  logic [N_SRC-1:0]        locked;

  // Address decode
  acc_e              acc;
  logic [31:0]       a32;
  logic [31:0]       ofs;
  logic [31:0]       wrd;
  logic [ID_W-1:0]   sel_id;
  logic [CTX_W-1:0]  sel_ctx;
  logic [WORD_W-1:0] sel_word;

  always_comb begin
    a32      = 32'(bus_addr);
    acc      = ACC_NONE;
    ofs      = '0;
    wrd      = '0;
    sel_id   = '0;
    sel_ctx  = '0;
    sel_word = '0;
    if (a32 < PRIO_LIMIT) begin
      ofs = a32 >> 2;
      if (ofs != 0 && ofs < N_SRC) begin
        acc    = ACC_PRIO;
        sel_id = ID_W'(ofs);
      end
    end else if (a32 >= EN_BASE && a32 < EN_BASE + EN_STRIDE * N_CTX) begin
      ofs = (a32 - EN_BASE) >> 7;
      wrd = (a32 >> 2) & 32'h1F;
      if (wrd < N_WORDS) begin
        acc      = ACC_EN;
        sel_ctx  = CTX_W'(ofs);
        sel_word = WORD_W'(wrd);
      end
    end else if (a32 >= CTX_BASE && a32 < CTX_BASE + CTX_STRIDE * N_CTX) begin
      ofs     = (a32 - CTX_BASE) >> 12;
      wrd     = (a32 >> 2) & 32'h3FF;
      sel_ctx = CTX_W'(ofs);
      if (wrd == 0) begin
        acc = ACC_THR;
      end else if (wrd == 1) begin
        acc = ACC_CLAIM;
      end
    end
  end

  logic            rd_req;
  logic            wr_req;
  logic            claim_fire;
  logic [ID_W-1:0] claim_id;
  logic            done_fire;
  logic [ID_W-1:0] done_id;

  assign rd_req     = bus_valid & ~bus_write;
  assign wr_req     = bus_valid & bus_write;
  assign claim_id   = best_id[sel_ctx];
  assign claim_fire = rd_req && (acc == ACC_CLAIM) && (claim_id != '0);
  assign done_fire  = wr_req && (acc == ACC_CLAIM) && (bus_wdata != 0) && (bus_wdata < N_SRC);
  assign done_id    = ID_W'(bus_wdata);
  assign bus_ready  = 1'b1;

  // Configuration storage
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_SRC; i++) prio_q[i] <= '0;
      for (int c = 0; c < N_CTX; c++) begin
        en_q[c]  <= '0;
        thr_q[c] <= '0;
      end
    end else if (wr_req) begin
      case (acc)
        ACC_PRIO: prio_q[sel_id] <= bus_wdata[PRIO_W-1:0];
        ACC_THR:  thr_q[sel_ctx] <= bus_wdata[PRIO_W-1:0];
        ACC_EN: begin
          for (int id = 1; id < N_SRC; id++) begin
            if ((id >> 5) == int'(sel_word)) begin
              en_q[sel_ctx][id] <= bus_wdata[id % 32];
            end
          end
        end
        default: ;
      endcase
    end
  end

  // Read path
  logic [31:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (acc)
      ACC_PRIO:  rd_mux = 32'(prio_q[sel_id]);
      ACC_THR:   rd_mux = 32'(thr_q[sel_ctx]);
      ACC_CLAIM: rd_mux = 32'(claim_id);
      ACC_EN: begin
        for (int id = 0; id < N_SRC; id++) begin
          if ((id >> 5) == int'(sel_word)) begin
            rd_mux[id % 32] = en_q[sel_ctx][id];
          end
        end
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
      ctx_irq    <= '0;
    end else begin
      bus_rvalid <= rd_req;
      bus_rdata  <= rd_req ? rd_mux : '0;
      ctx_irq    <= ctx_any;
    end
  end

  // Source gateways
  eic_gateway #(
    .N_SRC     (N_SRC),
    .N_CTX     (N_CTX),
    .EDGE_MASK (EDGE_MASK)
  ) u_gateway (
    .clk        (clk),
    .rst        (rst),
    .irq_src    (irq_src),
    .claim_fire (claim_fire),
    .claim_id   (claim_id),
    .claim_ctx  (sel_ctx),
    .done_fire  (done_fire),
    .done_id    (done_id),
    .done_ctx   (sel_ctx),
    .pend       (pend),
    .locked     (locked)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_pflat
    assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
  end

  // Per-context arbitration
  for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
    eic_arbiter #(
      .N_SRC  (N_SRC),
      .PRIO_W (PRIO_W)
    ) u_arb (
      .prio_flat (prio_flat),
      .en        (en_q[c]),
      .pend      (pend),
      .locked    (locked),
      .thr       (thr_q[c]),
      .best_id   (best_id[c]),
      .any       (ctx_any[c])
    );
    assign thr_flat[c*PRIO_W +: PRIO_W] = thr_q[c];
    assign best_flat[c*ID_W +: ID_W]    = best_id[c];
  end

endmodule

// File: rtl/eic_checker.sv
module eic_checker #(
  parameter int N_SRC  = 16,
  parameter int N_CTX  = 2,
  parameter int PRIO_W = 3,
  localparam int ID_W  = $clog2(N_SRC)
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    bus_valid,
  input logic                    bus_write,
  input logic [31:0]             bus_rdata,
  input logic                    claim_fire,
  input logic [N_SRC-1:0]        locked,
  input logic [N_SRC*PRIO_W-1:0] prio_flat,
  input logic [N_CTX*PRIO_W-1:0] thr_flat,
  input logic [N_CTX*ID_W-1:0]   best_flat
);

  // R6: a non-zero ID returned by a claim read belongs to a locked source
  assert_claim_locks_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(claim_fire) && (bus_rdata != 0)) |-> locked[bus_rdata[ID_W-1:0]]);

  for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
    logic [ID_W-1:0]   best;
    logic [PRIO_W-1:0] thr;
    assign best = best_flat[c*ID_W +: ID_W];
    assign thr  = thr_flat[c*PRIO_W +: PRIO_W];

    // R6: the arbiter never offers a locked source
    assert_winner_unlocked_R6: assert property (@(posedge clk) disable iff (rst)
      (best != '0) |-> !locked[best]);

    // R4: the offered source is above the context threshold
    assert_winner_above_thr_R4: assert property (@(posedge clk) disable iff (rst)
      (best != '0) |-> (prio_flat[best*PRIO_W +: PRIO_W] > thr));
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    // R6: a lock appears only through a claim read
    assert_lock_by_claim_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(locked[i]) |-> $past(claim_fire));

    // R6: a lock is released only by a register write
    assert_lock_held_R6: assert property (@(posedge clk) disable iff (rst)
      ($past(locked[i]) && !$past(bus_valid && bus_write)) |-> locked[i]);
  end

endmodule

bind ext_irq_ctrl eic_checker #(
  .N_SRC  (N_SRC),
  .N_CTX  (N_CTX),
  .PRIO_W (PRIO_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_rdata  (bus_rdata),
  .claim_fire (claim_fire),
  .locked     (locked),
  .prio_flat  (prio_flat),
  .thr_flat   (thr_flat),
  .best_flat  (best_flat)
);

// File: tb/tb_ext_irq_ctrl.sv
module tb_ext_irq_ctrl;

  localparam int N_SRC  = 16;
  localparam int N_CTX  = 2;
  localparam int ADDR_W = 26;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [N_SRC-1:0]  irq_src = '0;
  logic              bus_valid = 1'b0;
  logic              bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic              bus_ready;
  logic              bus_rvalid;
  logic [31:0]       bus_rdata;
  logic [N_CTX-1:0]  ctx_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic wr_rvalid;
  logic rd_rvalid;

  always #5 clk = ~clk;

  ext_irq_ctrl dut (
    .clk        (clk),
    .rst        (rst),
    .irq_src    (irq_src),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_ready  (bus_ready),
    .bus_rvalid (bus_rvalid),
    .bus_rdata  (bus_rdata),
    .ctx_irq    (ctx_irq)
  );

  function automatic logic [31:0] a_prio(int id); return 32'(4 * id); endfunction
  function automatic logic [31:0] a_en(int c, int w); return 32'h2000 + 32'(128 * c) + 32'(4 * w); endfunction
  function automatic logic [31:0] a_thr(int c); return 32'h200000 + 32'(4096 * c); endfunction
  function automatic logic [31:0] a_clm(int c); return 32'h200004 + 32'(4096 * c); endfunction

  function automatic int pat_prio(int p, int id);
    if (p == 3) return (id % 3) + 1;
    return ((id * (2 * p + 1)) + p) % 8;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1;
    bus_write = 1'b1;
    bus_addr  = a[ADDR_W-1:0];
    bus_wdata = d;
    @(negedge clk);
    wr_rvalid = bus_rvalid;
    bus_valid = 1'b0;
    bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1;
    bus_write = 1'b0;
    bus_addr  = a[ADDR_W-1:0];
    @(negedge clk);
    d         = bus_rdata;
    rd_rvalid = bus_rvalid;
    bus_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_rd(input string req, input logic [31:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    check(req, d, exp);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    int order_exp;
    bit taken [N_SRC];

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 ctx_irq", 32'(ctx_irq), 0);
    expect_rd("R1 claim ctx0", a_clm(0), 0);
    expect_rd("R1 claim ctx1", a_clm(1), 0);
    expect_rd("R1 prio id5", a_prio(5), 0);
    expect_rd("R1 enable ctx1", a_en(1, 0), 0);
    expect_rd("R1 threshold ctx0", a_thr(0), 0);

    // R10: handshake and read response
    check("R10 ready", 32'(bus_ready), 1);
    bus_rd(a_prio(1), d);
    check("R10 rvalid on read", 32'(rd_rvalid), 1);
    bus_wr(a_prio(1), 32'h0);
    check("R10 rvalid on write", 32'(wr_rvalid), 0);

    // R2: priority registers, full sweep
    for (int id = 1; id < N_SRC; id++) bus_wr(a_prio(id), 32'hFFFF_FFF0 | 32'(id));
    for (int id = 1; id < N_SRC; id++) expect_rd("R2 prio readback", a_prio(id), 32'(id & 7));
    bus_wr(a_prio(0), 32'h7);
    expect_rd("R2 source 0", a_prio(0), 0);
    bus_wr(a_prio(N_SRC), 32'h7);
    expect_rd("R2 past last source", a_prio(N_SRC), 0);
    bus_wr(32'h3000, 32'hFFFF_FFFF);
    expect_rd("R2 unmapped hole", 32'h3000, 0);
    expect_rd("R2 unmapped page word", 32'h200008, 0);
    expect_rd("R2 missing context", a_thr(N_CTX), 0);
    bus_wr(a_thr(1), 32'hFFFF_FFFD);
    expect_rd("R2 threshold readback", a_thr(1), 5);
    bus_wr(a_thr(1), 0);

    // R3: enable vectors
    bus_wr(a_en(0, 0), 32'hFFFF_FFFF);
    expect_rd("R3 ctx0 enables", a_en(0, 0), 32'h0000_FFFE);
    bus_wr(a_en(1, 0), 32'h0000_A5A5);
    expect_rd("R3 ctx1 enables", a_en(1, 0), 32'h0000_A5A4);
    expect_rd("R3 word beyond sources", a_en(0, 1), 0);

    // R4, R5, R6, R7: threshold x priority-pattern sweep on level sources 1..7
    irq_src = 16'h00FE;
    for (int p = 0; p < 4; p++) begin
      for (int t = 0; t < 8; t++) begin
        int any_exp;
        for (int id = 1; id < 8; id++) bus_wr(a_prio(id), 32'(pat_prio(p, id)));
        bus_wr(a_thr(0), 32'(t));
        settle();
        any_exp = 0;
        for (int id = 1; id < 8; id++) if (pat_prio(p, id) > t) any_exp = 1;
        check("R4 ctx_irq before drain", 32'(ctx_irq[0]), 32'(any_exp));
        for (int id = 0; id < N_SRC; id++) taken[id] = 1'b0;
        for (int k = 0; k < 8; k++) begin
          int bp;
          bp = t;
          order_exp = 0;
          for (int id = 1; id < 8; id++) begin
            if (!taken[id] && pat_prio(p, id) > bp) begin
              bp = pat_prio(p, id);
              order_exp = id;
            end
          end
          expect_rd("R5 claim order", a_clm(0), 32'(order_exp));
          if (order_exp == 0) break;
          taken[order_exp] = 1'b1;
        end
        settle();
        check("R6 ctx_irq after drain", 32'(ctx_irq[0]), 0);
        for (int id = 1; id < 8; id++) if (taken[id]) bus_wr(a_clm(0), 32'(id));
      end
    end
    irq_src = '0;
    settle();
    bus_wr(a_thr(0), 0);
    for (int id = 1; id < 8; id++) bus_wr(a_prio(id), 1);
    settle();
    check("R7 inputs low clear irq", 32'(ctx_irq), 0);

    // R6: lock across contexts (source 2 enabled in both)
    irq_src[2] = 1'b1;
    settle();
    expect_rd("R6 claim by ctx1", a_clm(1), 2);
    settle();
    check("R6 ctx1 irq after claim", 32'(ctx_irq[1]), 0);
    expect_rd("R6 locked hidden from ctx0", a_clm(0), 0);
    bus_wr(a_clm(0), 2);
    bus_wr(a_clm(1), 0);
    bus_wr(a_clm(1), 32'(N_SRC + 2));
    settle();
    expect_rd("R6 foreign complete ignored ctx0", a_clm(0), 0);
    expect_rd("R6 foreign complete ignored ctx1", a_clm(1), 0);
    bus_wr(a_clm(1), 2);
    settle();
    expect_rd("R6 released then ctx0 claims", a_clm(0), 2);
    bus_wr(a_clm(0), 2);
    irq_src[2] = 1'b0;
    settle();

    // R7: level withdrawal and re-forwarding
    bus_wr(a_prio(3), 4);
    irq_src[3] = 1'b1;
    settle();
    check("R7 level raises irq", 32'(ctx_irq[0]), 1);
    irq_src[3] = 1'b0;
    settle();
    check("R7 withdrawn irq", 32'(ctx_irq[0]), 0);
    expect_rd("R7 withdrawn claim", a_clm(0), 0);
    irq_src[3] = 1'b1;
    settle();
    expect_rd("R7 first claim", a_clm(0), 3);
    bus_wr(a_clm(0), 3);
    settle();
    expect_rd("R7 re-forward after complete", a_clm(0), 3);
    bus_wr(a_clm(0), 3);
    irq_src[3] = 1'b0;
    settle();

    // R9: exact output timing
    @(negedge clk);
    irq_src[3] = 1'b1;
    @(negedge clk);
    check("R9 one edge after input", 32'(ctx_irq[0]), 0);
    @(negedge clk);
    check("R9 two edges after input", 32'(ctx_irq[0]), 1);
    bus_rd(a_clm(0), d);
    check("R9 claim value", d, 3);
    check("R9 still high at claim edge", 32'(ctx_irq[0]), 1);
    @(negedge clk);
    check("R9 low one edge after claim", 32'(ctx_irq[0]), 0);
    bus_wr(a_clm(0), 3);
    irq_src[3] = 1'b0;
    settle();

    // R8: edge source 9
    bus_wr(a_prio(9), 5);
    @(negedge clk);
    irq_src[9] = 1'b1;
    @(negedge clk);
    irq_src[9] = 1'b0;
    settle();
    check("R8 edge latched", 32'(ctx_irq[0]), 1);
    expect_rd("R8 edge claim", a_clm(0), 9);
    expect_rd("R8 one request per edge", a_clm(0), 0);
    @(negedge clk);
    irq_src[9] = 1'b1;
    @(negedge clk);
    irq_src[9] = 1'b0;
    settle();
    expect_rd("R8 edge while locked hidden", a_clm(0), 0);
    bus_wr(a_clm(0), 9);
    settle();
    expect_rd("R8 kept edge forwarded", a_clm(0), 9);
    bus_wr(a_clm(0), 9);
    settle();
    expect_rd("R8 nothing left", a_clm(0), 0);
    check("R8 irq idle", 32'(ctx_irq), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule